// File: doc/BRIEF.md
# Banked UART Register Interface

This block is the processor-facing register interface of one channel of a 16550-style UART that has an extra bank of enhanced registers. The host sees eight byte locations through a 3-bit address, a chip select and separate read and write strobes. Which register a location reaches depends on the address and on three stored settings: the line control byte, a fractional-divisor enable flag in the enhanced function register, and a level-select flag in the feature control register. Loading the line control byte with the key value 0xBF switches all locations except address 3 to the enhanced bank. When the divisor-access bit is set and both divisor bytes are zero, reads of the first two locations return identity codes.

The block holds every writable register and sends each one out on its own port. Read data is built without a clock from the address, the stored settings and status inputs supplied by the serial engine, the FIFOs and the interrupt logic. The clock edge that follows an access raises one-cycle pulses that push a byte into the transmit FIFO, load the FIFO control byte, or pop the receive FIFO. The block holds no FIFO, baud generator or serial logic.

Top module: `uart_regbank_decode`

## Requirements
- R1: Synchronous active-high reset clears every stored register to 0x00, which selects the normal bank, and holds all pulse outputs low.
- R2: In the normal bank (line control bit 7 = 0), address 0 returns the receive data input on reads. A write to address 0 raises tx_push_o for one cycle on the next clock edge, with tx_data_o holding the written byte. Address 1 is the read/write interrupt enable register.
- R3: With line control bit 7 = 1 and line control not 0xBF (divisor bank), addresses 0 and 1 are the read/write divisor low and high bytes. A write there does not push the transmit FIFO.
- R4: Address 2 reaches the read/write fractional divisor only in the divisor bank with enhanced-function bit 4 = 1. In every other case outside the enhanced bank, address 2 returns the interrupt status input on reads, and a write raises fcr_load_o for one cycle with fcr_data_o holding the byte.
- R5: In the divisor bank with both divisor bytes 0x00, reads of address 0 return the REV_CODE parameter and reads of address 1 return the DEV_ID parameter. Writes in this state still reach the divisor bytes.
- R6: Address 3 is the read/write line control register in every bank. Outside the enhanced bank, address 4 is the read/write modem control register.
- R7: Outside the enhanced bank, addresses 5 and 6 return the line status and modem status inputs. A write to either leaves every stored register unchanged.
- R8: Outside the enhanced bank, address 7 is a read/write scratch byte while feature-control bit 6 = 0. While that bit is 1, reads return the FIFO level input and writes go to the write-only mode select register.
- R9: With line control equal to 0xBF, the map is as follows. Address 0 writes the trigger-level register and reads the FIFO level input. Address 1 is feature control and address 2 is enhanced function. Addresses 4, 5, 6 and 7 are the Xon1, Xon2, Xoff1 and Xoff2 characters.
- R10: An access needs cs_i high and exactly one strobe. With both strobes high, or cs_i low, nothing is stored and no pulse is raised. Each pulse lasts one cycle for each accepted access.
- R11: A read of address 0 in the normal bank raises rx_pop_o for one cycle on the next clock edge. No other read raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Channel select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register location |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| rx_data_i | input | 8 | Head byte of the receive FIFO |
| isr_i | input | 8 | Interrupt status byte |
| lsr_i | input | 8 | Line status byte |
| msr_i | input | 8 | Modem status byte |
| lvl_i | input | 8 | FIFO level count |
| rx_pop_o | output | 1 | Receive FIFO pop pulse |
| tx_push_o | output | 1 | Transmit FIFO push pulse |
| tx_data_o | output | 8 | Byte to push |
| fcr_load_o | output | 1 | FIFO control load pulse |
| fcr_data_o | output | 8 | FIFO control byte |
| lcr_o | output | 8 | Line control register |
| ier_o | output | 8 | Interrupt enable register |
| mcr_o | output | 8 | Modem control register |
| dll_o | output | 8 | Divisor low byte |
| dlm_o | output | 8 | Divisor high byte |
| dld_o | output | 8 | Fractional divisor |
| efr_o | output | 8 | Enhanced function register |
| fctr_o | output | 8 | Feature control register |
| trg_o | output | 8 | Trigger-level register |
| emsr_o | output | 8 | Mode select register |
| xon1_o | output | 8 | Xon character 1 |
| xon2_o | output | 8 | Xon character 2 |
| xoff1_o | output | 8 | Xoff character 1 |
| xoff2_o | output | 8 | Xoff character 2 |

## Verification
Directed sequences visit each bank in turn. One sets line control to 0x83 while both divisor bytes are zero, which separates the identity codes from the divisor values. Others toggle enhanced-function bit 4 and feature-control bit 6, which separates the fractional divisor from the status/FIFO-control location and the scratch byte from the level/mode-select pair. Writes of 0xBF show the enhanced map replacing the normal one. Random operations then mix line control values of 0x03, 0x83, 0xBF and arbitrary bytes with accesses that carry both strobes or no select, so that a dropped or misrouted write or pulse appears in the stored registers or on the pulse ports.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    localparam int DW = 8;
    localparam int AW = 3;
    localparam logic [DW-1:0] ENH_KEY = 8'hBF;
    localparam int DLAB_BIT    = 7;
    localparam int FRAC_EN_BIT = 4;
    localparam int LVL_SEL_BIT = 6;

    typedef enum logic [1:0] {BK_NORM, BK_DIV, BK_ENH} bank_e;

    typedef enum logic [4:0] {
        T_NONE, T_RHR, T_THR, T_IER, T_DLL, T_DLM, T_DLD, T_REV, T_DID,
        T_ISR, T_FCR, T_LCR, T_MCR, T_LSR, T_MSR, T_SPR, T_LVL, T_EMSR,
        T_TRG, T_CTR, T_EFR, T_XON1, T_XON2, T_XOFF1, T_XOFF2
    } tgt_e;

    typedef enum logic [3:0] {
        R_LCR, R_IER, R_MCR, R_DLL, R_DLM, R_DLD, R_SPR, R_EMSR,
        R_TRG, R_CTR, R_EFR, R_XON1, R_XON2, R_XOFF1, R_XOFF2
    } wreg_e;

    localparam int NWREG = 15;

    typedef struct packed {
        bank_e bank;
        logic  frac_en;
        logic  lvl_sel;
        logic  div_zero;
    } mode_t;

    typedef struct packed {
        logic  hit;
        wreg_e idx;
    } wsel_t;

    function automatic bank_e bank_of(logic [DW-1:0] lcr);
        if (lcr == ENH_KEY)      return BK_ENH;
        else if (lcr[DLAB_BIT])  return BK_DIV;
        else                     return BK_NORM;
    endfunction

    function automatic tgt_e map_target(mode_t m, logic [AW-1:0] a, logic is_wr);
        tgt_e t;
        t = T_NONE;
        if (a == 3'd3) begin
            t = T_LCR;
        end else if (m.bank == BK_ENH) begin
            case (a)
                3'd0: t = is_wr ? T_TRG : T_LVL;
                3'd1: t = T_CTR;
                3'd2: t = T_EFR;
                3'd4: t = T_XON1;
                3'd5: t = T_XON2;
                3'd6: t = T_XOFF1;
                3'd7: t = T_XOFF2;
                default: t = T_NONE;
            endcase
        end else begin
            case (a)
                3'd0: if (m.bank == BK_DIV) t = (!is_wr && m.div_zero) ? T_REV : T_DLL;
                      else                  t = is_wr ? T_THR : T_RHR;
                3'd1: if (m.bank == BK_DIV) t = (!is_wr && m.div_zero) ? T_DID : T_DLM;
                      else                  t = T_IER;
                3'd2: if (m.bank == BK_DIV && m.frac_en) t = T_DLD;
                      else                               t = is_wr ? T_FCR : T_ISR;
                3'd4: t = T_MCR;
                3'd5: t = is_wr ? T_NONE : T_LSR;
                3'd6: t = is_wr ? T_NONE : T_MSR;
                3'd7: if (m.lvl_sel) t = is_wr ? T_EMSR : T_LVL;
                      else           t = T_SPR;
                default: t = T_NONE;
            endcase
        end
        return t;
    endfunction

    function automatic wsel_t slot_of(tgt_e t);
        wsel_t s;
        s.hit = 1'b1;
        s.idx = R_LCR;
        case (t)
            T_LCR:   s.idx = R_LCR;
            T_IER:   s.idx = R_IER;
            T_MCR:   s.idx = R_MCR;
            T_DLL:   s.idx = R_DLL;
            T_DLM:   s.idx = R_DLM;
            T_DLD:   s.idx = R_DLD;
            T_SPR:   s.idx = R_SPR;
            T_EMSR:  s.idx = R_EMSR;
            T_TRG:   s.idx = R_TRG;
            T_CTR:   s.idx = R_CTR;
            T_EFR:   s.idx = R_EFR;
            T_XON1:  s.idx = R_XON1;
            T_XON2:  s.idx = R_XON2;
            T_XOFF1: s.idx = R_XOFF1;
            T_XOFF2: s.idx = R_XOFF2;
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
    import uart_rb_pkg::*;
(
    input  logic [DW-1:0] ctl_lcr,
    input  logic          frac_en,
    input  logic          lvl_sel,
    input  logic [DW-1:0] div_lo,
    input  logic [DW-1:0] div_hi,
    input  logic [AW-1:0] addr,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    output tgt_e          rd_tgt,
    output tgt_e          wr_tgt,
    output logic          rd_en,
    output logic          wr_en
);
    mode_t mode;

    always_comb begin
        mode.bank     = bank_of(ctl_lcr);
        mode.frac_en  = frac_en;
        mode.lvl_sel  = lvl_sel;
        mode.div_zero = (div_lo == '0) && (div_hi == '0);
        rd_tgt = map_target(mode, addr, 1'b0);
        wr_tgt = map_target(mode, addr, 1'b1);
        rd_en  = cs && rd && !wr;
        wr_en  = cs && wr && !rd;
    end
endmodule

// File: rtl/uart_rb_regs.sv
module uart_rb_regs
    import uart_rb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  tgt_e                       wr_tgt,
    input  logic [DW-1:0]              wdata,
    output logic [NWREG-1:0][DW-1:0]   q
);
    wsel_t sel;
    assign sel = slot_of(wr_tgt);

    for (genvar g = 0; g < NWREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= '0;
            else if (wr_en && sel.hit && sel.idx == wreg_e'(g))
                q[g] <= wdata;
        end
    end

    // Feature control changes only through a write made while the key value was loaded
    p_ctr_key_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(q[R_CTR]) |-> $past(q[R_LCR]) == ENH_KEY);
endmodule

// File: rtl/uart_rb_strobe.sv
module uart_rb_strobe
    import uart_rb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          wr_en,
    input  tgt_e          rd_tgt,
    input  tgt_e          wr_tgt,
    input  logic [DW-1:0] wdata,
    output logic          rx_pop,
    output logic          tx_push,
    output logic [DW-1:0] tx_data,
    output logic          fcr_load,
    output logic [DW-1:0] fcr_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_pop   <= 1'b0;
            tx_push  <= 1'b0;
            fcr_load <= 1'b0;
            tx_data  <= '0;
            fcr_data <= '0;
        end else begin
            rx_pop   <= rd_en && (rd_tgt == T_RHR);
            tx_push  <= wr_en && (wr_tgt == T_THR);
            fcr_load <= wr_en && (wr_tgt == T_FCR);
            if (wr_en && wr_tgt == T_THR) tx_data  <= wdata;
            if (wr_en && wr_tgt == T_FCR) fcr_data <= wdata;
        end
    end
endmodule

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
    import uart_rb_pkg::*;
#(
    parameter logic [7:0] REV_CODE = 8'h01,
    parameter logic [7:0] DEV_ID   = 8'h2A
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_i,
    input  logic       rd_i,
    input  logic       wr_i,
    input  logic [2:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic [7:0] rx_data_i,
    input  logic [7:0] isr_i,
    input  logic [7:0] lsr_i,
    input  logic [7:0] msr_i,
    input  logic [7:0] lvl_i,
    output logic       rx_pop_o,
    output logic       tx_push_o,
    output logic [7:0] tx_data_o,
    output logic       fcr_load_o,
    output logic [7:0] fcr_data_o,
    output logic [7:0] lcr_o,
    output logic [7:0] ier_o,
    output logic [7:0] mcr_o,
    output logic [7:0] dll_o,
    output logic [7:0] dlm_o,
    output logic [7:0] dld_o,
    output logic [7:0] efr_o,
    output logic [7:0] fctr_o,
    output logic [7:0] trg_o,
    output logic [7:0] emsr_o,
    output logic [7:0] xon1_o,
    output logic [7:0] xon2_o,
    output logic [7:0] xoff1_o,
    output logic [7:0] xoff2_o
);
    logic [NWREG-1:0][DW-1:0] q;
    tgt_e rd_tgt, wr_tgt;
    logic rd_en, wr_en;

    uart_rb_decode u_dec (
        .ctl_lcr (q[R_LCR]),
        .frac_en (q[R_EFR][FRAC_EN_BIT]),
        .lvl_sel (q[R_CTR][LVL_SEL_BIT]),
        .div_lo  (q[R_DLL]),
        .div_hi  (q[R_DLM]),
        .addr    (addr_i),
        .cs      (cs_i),
        .rd      (rd_i),
        .wr      (wr_i),
        .rd_tgt  (rd_tgt),
        .wr_tgt  (wr_tgt),
        .rd_en   (rd_en),
        .wr_en   (wr_en)
    );

    uart_rb_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_tgt (wr_tgt),
        .wdata  (wdata_i),
        .q      (q)
    );

    uart_rb_strobe u_stb (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .rd_tgt   (rd_tgt),
        .wr_tgt   (wr_tgt),
        .wdata    (wdata_i),
        .rx_pop   (rx_pop_o),
        .tx_push  (tx_push_o),
        .tx_data  (tx_data_o),
        .fcr_load (fcr_load_o),
        .fcr_data (fcr_data_o)
    );

    always_comb begin
        case (rd_tgt)
            T_RHR:   rdata_o = rx_data_i;
            T_ISR:   rdata_o = isr_i;
            T_LSR:   rdata_o = lsr_i;
            T_MSR:   rdata_o = msr_i;
            T_LVL:   rdata_o = lvl_i;
            T_REV:   rdata_o = REV_CODE;
            T_DID:   rdata_o = DEV_ID;
            T_LCR:   rdata_o = q[R_LCR];
            T_IER:   rdata_o = q[R_IER];
            T_MCR:   rdata_o = q[R_MCR];
            T_DLL:   rdata_o = q[R_DLL];
            T_DLM:   rdata_o = q[R_DLM];
            T_DLD:   rdata_o = q[R_DLD];
            T_SPR:   rdata_o = q[R_SPR];
            T_CTR:   rdata_o = q[R_CTR];
            T_EFR:   rdata_o = q[R_EFR];
            T_XON1:  rdata_o = q[R_XON1];
            T_XON2:  rdata_o = q[R_XON2];
            T_XOFF1: rdata_o = q[R_XOFF1];
            T_XOFF2: rdata_o = q[R_XOFF2];
            default: rdata_o = '0;
        endcase
    end

    assign lcr_o   = q[R_LCR];
    assign ier_o   = q[R_IER];
    assign mcr_o   = q[R_MCR];
    assign dll_o   = q[R_DLL];
    assign dlm_o   = q[R_DLM];
    assign dld_o   = q[R_DLD];
    assign efr_o   = q[R_EFR];
    assign fctr_o  = q[R_CTR];
    assign trg_o   = q[R_TRG];
    assign emsr_o  = q[R_EMSR];
    assign xon1_o  = q[R_XON1];
    assign xon2_o  = q[R_XON2];
    assign xoff1_o = q[R_XOFF1];
    assign xoff2_o = q[R_XOFF2];

    p_push_src_r2: assert property (@(posedge clk) disable iff (rst)
        tx_push_o |-> $past(cs_i && wr_i && !rd_i && addr_i == 3'd0 && !lcr_o[DLAB_BIT]));

    p_fcr_src_r4: assert property (@(posedge clk) disable iff (rst)
        fcr_load_o |-> $past(cs_i && wr_i && !rd_i && addr_i == 3'd2 && lcr_o != ENH_KEY));

    p_pop_src_r11: assert property (@(posedge clk) disable iff (rst)
        rx_pop_o |-> $past(cs_i && rd_i && !wr_i && addr_i == 3'd0 && !lcr_o[DLAB_BIT]));

    p_lcr_only_r6: assert property (@(posedge clk) disable iff (rst)
        !(cs_i && wr_i && !rd_i && addr_i == 3'd3) |=> $stable(lcr_o));

    p_status_ro_r7: assert property (@(posedge clk) disable iff (rst)
        (cs_i && wr_i && !rd_i && (addr_i == 3'd5 || addr_i == 3'd6) && lcr_o != ENH_KEY)
        |=> $stable({lcr_o, ier_o, mcr_o, dll_o, dlm_o, dld_o, efr_o, fctr_o,
                     trg_o, emsr_o, xon1_o, xon2_o, xoff1_o, xoff2_o}));

    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_pop_o, tx_push_o, fcr_load_o}));

    p_dual_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        (cs_i && rd_i && wr_i) |=> !(rx_pop_o || tx_push_o || fcr_load_o));
endmodule

// File: tb/sim_uart_regbank_decode.sv
module sim_uart_regbank_decode;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       cs = 0, rd = 0, wr = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic [7:0] rx = 0, isr = 0, lsr = 0, msr = 0, lvl = 0;
    logic       rx_pop, tx_push, fcr_load;
    logic [7:0] tx_data, fcr_data;
    logic [7:0] lcr, ier, mcr, dll, dlm, dld, efr, fctr, trg, emsr, xon1, xon2, xoff1, xoff2;

    localparam logic [7:0] REV = 8'h11;
    localparam logic [7:0] DID = 8'hC4;

    uart_regbank_decode #(.REV_CODE(REV), .DEV_ID(DID)) u0 (
        .clk(clk), .rst(rst), .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx), .isr_i(isr), .lsr_i(lsr),
        .msr_i(msr), .lvl_i(lvl), .rx_pop_o(rx_pop), .tx_push_o(tx_push),
        .tx_data_o(tx_data), .fcr_load_o(fcr_load), .fcr_data_o(fcr_data),
        .lcr_o(lcr), .ier_o(ier), .mcr_o(mcr), .dll_o(dll), .dlm_o(dlm), .dld_o(dld),
        .efr_o(efr), .fctr_o(fctr), .trg_o(trg), .emsr_o(emsr), .xon1_o(xon1),
        .xon2_o(xon2), .xoff1_o(xoff1), .xoff2_o(xoff2)
    );

    int vecs = 0;
    int errs = 0;

    logic [7:0] s_lcr, s_ier, s_mcr, s_dll, s_dlm, s_dld, s_spr, s_efr, s_fctr;
    logic [7:0] s_trg, s_emsr, s_xon1, s_xon2, s_xoff1, s_xoff2;
    logic       e_push, e_fcr, e_pop;
    logic [7:0] e_txd, e_fcrd;

    task automatic chk(input string rq, input string what, input logic [111:0] act, input logic [111:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [111:0] dut_cfg();
        return {lcr, ier, mcr, dll, dlm, dld, efr, fctr, trg, emsr, xon1, xon2, xoff1, xoff2};
    endfunction

    function automatic logic [111:0] exp_cfg();
        return {s_lcr, s_ier, s_mcr, s_dll, s_dlm, s_dld, s_efr, s_fctr, s_trg, s_emsr,
                s_xon1, s_xon2, s_xoff1, s_xoff2};
    endfunction

    // Expected read value at address a for the current shadow state
    function automatic logic [7:0] m_read(input logic [2:0] a, output string rq);
        bit enh, dv, dz;
        enh = (s_lcr == 8'hBF);
        dv  = s_lcr[7] && !enh;
        dz  = (s_dll == 8'h00) && (s_dlm == 8'h00);
        if (a == 3'd3) begin rq = "R6"; return s_lcr; end
        if (enh) begin
            rq = "R9";
            case (a)
                3'd0: return lvl;
                3'd1: return s_fctr;
                3'd2: return s_efr;
                3'd4: return s_xon1;
                3'd5: return s_xon2;
                3'd6: return s_xoff1;
                default: return s_xoff2;
            endcase
        end
        case (a)
            3'd0: begin
                if (!dv) begin rq = "R2"; return rx; end
                rq = dz ? "R5" : "R3";
                return dz ? REV : s_dll;
            end
            3'd1: begin
                if (!dv) begin rq = "R2"; return s_ier; end
                rq = dz ? "R5" : "R3";
                return dz ? DID : s_dlm;
            end
            3'd2: begin rq = "R4"; return (dv && s_efr[4]) ? s_dld : isr; end
            3'd4: begin rq = "R6"; return s_mcr; end
            3'd5: begin rq = "R7"; return lsr; end
            3'd6: begin rq = "R7"; return msr; end
            default: begin rq = "R8"; return s_fctr[6] ? lvl : s_spr; end
        endcase
    endfunction

    task automatic m_write(input logic [2:0] a, input logic [7:0] d, output string rq);
        bit enh, dv;
        enh = (s_lcr == 8'hBF);
        dv  = s_lcr[7] && !enh;
        if (a == 3'd3) begin
            rq = "R6"; s_lcr = d;
        end else if (enh) begin
            rq = "R9";
            case (a)
                3'd0: s_trg = d;
                3'd1: s_fctr = d;
                3'd2: s_efr = d;
                3'd4: s_xon1 = d;
                3'd5: s_xon2 = d;
                3'd6: s_xoff1 = d;
                default: s_xoff2 = d;
            endcase
        end else begin
            case (a)
                3'd0: if (dv) begin rq = "R3"; s_dll = d; end
                      else begin rq = "R2"; e_push = 1; e_txd = d; end
                3'd1: if (dv) begin rq = "R3"; s_dlm = d; end
                      else begin rq = "R2"; s_ier = d; end
                3'd2: begin
                    rq = "R4";
                    if (dv && s_efr[4]) s_dld = d;
                    else begin e_fcr = 1; e_fcrd = d; end
                end
                3'd4: begin rq = "R6"; s_mcr = d; end
                3'd5, 3'd6: rq = "R7";
                default: begin
                    rq = "R8";
                    if (s_fctr[6]) s_emsr = d; else s_spr = d;
                end
            endcase
        end
    endtask

    // One access lasting one clock; called at a falling edge
    task automatic op(input bit c, input bit r, input bit w, input logic [2:0] a, input logic [7:0] d);
        string rq_r, rq_w;
        logic [7:0] er;
        cs = c; rd = r; wr = w; addr = a; wdata = d;
        rx = 8'($urandom); isr = 8'($urandom); lsr = 8'($urandom);
        msr = 8'($urandom); lvl = 8'($urandom);
        #1;
        er = m_read(a, rq_r);
        chk(rq_r, "rdata", {104'h0, rdata}, {104'h0, er});
        e_push = 0; e_fcr = 0; e_pop = 0;
        rq_w = "R10";
        if (c && w && !r) m_write(a, d, rq_w);
        if (c && r && !w && a == 3'd0 && !s_lcr[7]) e_pop = 1;
        @(negedge clk);
        chk("R2", "tx_push", {111'h0, tx_push}, {111'h0, e_push});
        if (e_push) chk("R2", "tx_data", {104'h0, tx_data}, {104'h0, e_txd});
        chk("R4", "fcr_load", {111'h0, fcr_load}, {111'h0, e_fcr});
        if (e_fcr) chk("R4", "fcr_data", {104'h0, fcr_data}, {104'h0, e_fcrd});
        chk("R11", "rx_pop", {111'h0, rx_pop}, {111'h0, e_pop});
        chk(rq_w, "registers", dut_cfg(), exp_cfg());
        cs = 0; rd = 0; wr = 0;
    endtask

    task automatic wr_op(input logic [2:0] a, input logic [7:0] d);
        op(1, 0, 1, a, d);
    endtask

    task automatic rd_op(input logic [2:0] a);
        op(1, 1, 0, a, 8'h00);
    endtask

    initial begin
        #2_000_000;
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        {s_lcr, s_ier, s_mcr, s_dll, s_dlm, s_dld, s_spr, s_efr, s_fctr} = '0;
        {s_trg, s_emsr, s_xon1, s_xon2, s_xoff1, s_xoff2} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1", "registers after reset", dut_cfg(), 112'h0);
        chk("R1", "pulses after reset", {109'h0, rx_pop, tx_push, fcr_load}, 112'h0);
        rx = 8'h5A; #1;
        chk("R1", "normal bank read after reset", {104'h0, rdata}, {104'h0, 8'h5A});
        @(negedge clk);

        // R2: normal bank
        wr_op(3'd0, 8'hA5);
        rd_op(3'd0);
        wr_op(3'd1, 8'h0F);
        rd_op(3'd1);
        // R4 FIFO control outside divisor bank, R6 modem control, R7 read-only status
        wr_op(3'd2, 8'hC7);
        rd_op(3'd2);
        wr_op(3'd4, 8'h13);
        wr_op(3'd5, 8'hFF);
        wr_op(3'd6, 8'hFF);
        rd_op(3'd5);
        rd_op(3'd6);
        // R8: scratch then level/mode select
        wr_op(3'd7, 8'h66);
        rd_op(3'd7);
        // R5: divisor bank with zero divisor returns identity codes
        wr_op(3'd3, 8'h83);
        op(1, 1, 0, 3'd0, 8'h00);
        chk("R5", "revision code literal", {104'h0, rdata}, {104'h0, REV});
        rd_op(3'd1);
        wr_op(3'd0, 8'h05);
        rd_op(3'd0);
        rd_op(3'd1);
        wr_op(3'd1, 8'h02);
        rd_op(3'd1);
        rd_op(3'd2);
        // R9: enhanced bank
        wr_op(3'd3, 8'hBF);
        wr_op(3'd2, 8'h10);
        wr_op(3'd1, 8'h40);
        wr_op(3'd0, 8'h9C);
        rd_op(3'd0);
        for (int i = 4; i < 8; i++) wr_op(3'(i), 8'(8'h30 + i));
        for (int i = 0; i < 8; i++) rd_op(3'(i));
        // R4: fractional divisor now enabled
        wr_op(3'd3, 8'h83);
        wr_op(3'd2, 8'h07);
        rd_op(3'd2);
        // R8: level select set
        wr_op(3'd3, 8'h03);
        rd_op(3'd7);
        wr_op(3'd7, 8'hE1);
        rd_op(3'd7);
        // R10: both strobes, no select
        op(1, 1, 1, 3'd0, 8'h44);
        op(0, 0, 1, 3'd3, 8'hBF);
        op(0, 1, 0, 3'd0, 8'h00);

        for (int n = 0; n < 1500; n++) begin
            int k;
            logic [2:0] a;
            logic [7:0] d;
            a = 3'($urandom);
            d = 8'($urandom);
            k = int'($urandom_range(0, 99));
            if (a == 3'd3) begin
                case ($urandom_range(0, 3))
                    0: d = 8'h03;
                    1: d = 8'h83;
                    2: d = 8'hBF;
                    default: ;
                endcase
            end
            if (a == 3'd0 && $urandom_range(0, 3) == 0) d = 8'h00;
            if (k < 44)      op(1, 1, 0, a, d);
            else if (k < 88) op(1, 0, 1, a, d);
            else if (k < 94) op(1, 1, 1, a, d);
            else             op(0, $urandom_range(0, 1) == 1, 1, a, d);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule